// File: doc/BRIEF.md
# Lockable Register Access Controller

This block is the byte-wide register file behind the host read/write port of a fan and hardware-monitor controller. Each access has an address, write data, a write strobe and a read strobe. The block decides whether a write lands and what a read returns. It holds the per-fan duty-cycle and mode registers, a test register, an interrupt status register, a special-function register and the configuration register. Their stored control values drive the rest of the chip.

Access rules depend on several things. A self-locking lock bit freezes most settings until reset. The start bit and a low-power bit together define a shutdown state, in which almost every register is hidden. Each fan's manual/auto selection decides whether its duty cycle may be written. The status register latches event inputs and clears on a host read, but only when no event is active in that cycle. Writes take effect at the clock edge on which the write strobe is high. Read data is combinational from the address while the read strobe is high.

Top module: `fanreg_access`

## Requirements
- R1: After reset every address reads 00h, all fans are in auto mode, and the lock, start, override, low-power and interrupt-enable outputs are 0.
- R2: A read of an address with no register returns 00h, a write to it changes nothing, and `rdata` is 00h whenever `rd` is low.
- R3: Fan i's duty register (address 30h+i) accepts a write only when bit 0 of fan i's mode register is 1 (manual) and lock is 0; otherwise the write is discarded.
- R4: Fan i's mode register (5Ch+i) is a full byte, with bit 0 selecting manual mode. The lock bit is bit 1 of the configuration register (7Fh). Writing 1 to lock sets it, and it then stays 1 until reset. While lock is 1, writes leave the mode registers, 7Ch bits [6:3] and 7Fh bits [7:3] unchanged.
- R5: Start (7Fh bit 0) and override (7Fh bit 2) accept every write, whatever the state of lock or start.
- R6: At 7Ch, bit 7 is the interrupt enable and bits [2:0] are plain storage. Bits [2:0] accept every write. The enable accepts every write except in shutdown.
- R7: The test register at 10h resets to 00h and is read/write regardless of lock.
- R8: The status register at 41h ORs in the `evt` inputs every cycle, and a read returns its current value. A read clears it only when `evt` is all zero in that cycle; otherwise it keeps its value plus the new events.
- R9: Shutdown is low-power (7Fh bit 3) = 1 with start = 0. In shutdown, 7Fh stays fully accessible and 7Ch reads as {00000b, bits [2:0]}. Every other register reads 00h and ignores writes, and a status read does not clear it.
- R10: Reserved bits (7Fh [7:4], 7Ch [6:3], mode bits [7:1]) read back what was written and drive no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| evt | input | 8 | Active-high event sources for the status register |
| rdata | output | 8 | Read data |
| duty_o | output | 8*NFAN | Stored duty cycles, fan i in bits [8i+7:8i] |
| manual_o | output | NFAN | Per-fan manual mode |
| ie_o | output | 1 | Interrupt enable |
| start_o | output | 1 | Start bit |
| lock_o | output | 1 | Lock bit |
| ovrd_o | output | 1 | Override bit |
| lpmd_o | output | 1 | Low-power mode bit |

## Verification
The assertions assume the host never raises `wr` and `rd` in the same cycle. They also assume `addr`, `wdata` and `evt` are stable across each clock edge. The bench drives every access as a single-strobe cycle, changing inputs only on falling edges. Event patterns are sparse and tied to the address, so some status reads meet an active event and others meet a quiet cycle. Repeated write sweeps over all 256 addresses reach the locked, unlocked, manual, auto and shutdown states.

// File: rtl/fanreg_access.sv
module fanreg_access #(
  parameter int NFAN = 3,
  parameter logic [7:0] DUTY_BASE = 8'h30,
  parameter logic [7:0] MODE_BASE = 8'h5C,
  parameter logic [7:0] TEST_ADDR = 8'h10,
  parameter logic [7:0] STAT_ADDR = 8'h41,
  parameter logic [7:0] SPEC_ADDR = 8'h7C,
  parameter logic [7:0] CFG_ADDR  = 8'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        evt,
  output logic [7:0]        rdata,
  output logic [8*NFAN-1:0] duty_o,
  output logic [NFAN-1:0]   manual_o,
  output logic              ie_o,
  output logic              start_o,
  output logic              lock_o,
  output logic              ovrd_o,
  output logic              lpmd_o
);

  logic [7:0] test_q, stat_q, cfg_q;
  logic       ie_q;
  logic [3:0] spec_rsv_q;
  logic [2:0] spec_lo_q;
  logic [NFAN-1:0][7:0] duty_q, mode_q;
  logic [7:0] rd_mux;

  wire lock = cfg_q[1];
  wire shdn = cfg_q[3] & ~cfg_q[0];
  wire wr_cfg  = wr && addr == CFG_ADDR;
  wire wr_spec = wr && addr == SPEC_ADDR;
  wire wr_open = wr && !shdn;
  wire stat_clr = rd && !shdn && addr == STAT_ADDR && evt == 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= 8'h00;
    end else if (wr_cfg) begin
      cfg_q[0] <= wdata[0];
      cfg_q[2] <= wdata[2];
      if (!lock) begin
        cfg_q[1]   <= wdata[1];
        cfg_q[7:3] <= wdata[7:3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q       <= 1'b0;
      spec_rsv_q <= 4'h0;
      spec_lo_q  <= 3'h0;
    end else if (wr_spec) begin
      spec_lo_q <= wdata[2:0];
      if (!shdn) ie_q <= wdata[7];
      if (!shdn && !lock) spec_rsv_q <= wdata[6:3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) test_q <= 8'h00;
    else if (wr_open && addr == TEST_ADDR) test_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= 8'h00;
    else if (stat_clr) stat_q <= 8'h00;
    else stat_q <= stat_q | evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q <= '0;
      mode_q <= '0;
    end else if (wr_open && !lock) begin
      for (int i = 0; i < NFAN; i++) begin
        if (addr == 8'(int'(DUTY_BASE) + i) && mode_q[i][0]) duty_q[i] <= wdata;
        if (addr == 8'(int'(MODE_BASE) + i)) mode_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (addr == CFG_ADDR) rd_mux = cfg_q;
    else if (addr == SPEC_ADDR) rd_mux = shdn ? {5'b0, spec_lo_q} : {ie_q, spec_rsv_q, spec_lo_q};
    else if (!shdn) begin
      if (addr == TEST_ADDR) rd_mux = test_q;
      if (addr == STAT_ADDR) rd_mux = stat_q;
      for (int i = 0; i < NFAN; i++) begin
        if (addr == 8'(int'(DUTY_BASE) + i)) rd_mux = duty_q[i];
        if (addr == 8'(int'(MODE_BASE) + i)) rd_mux = mode_q[i];
      end
    end
  end

  assign rdata = rd ? rd_mux : 8'h00;

  for (genvar g = 0; g < NFAN; g++) begin : g_fan
    assign duty_o[8*g +: 8] = duty_q[g];
    assign manual_o[g]      = mode_q[g][0];
  end

  assign ie_o    = ie_q;
  assign start_o = cfg_q[0];
  assign lock_o  = cfg_q[1];
  assign ovrd_o  = cfg_q[2];
  assign lpmd_o  = cfg_q[3];

endmodule

// File: rtl/fanreg_access_chk.sv
module fanreg_access_chk #(
  parameter int NFAN = 3,
  parameter logic [7:0] STAT_ADDR = 8'h41,
  parameter logic [7:0] SPEC_ADDR = 8'h7C,
  parameter logic [7:0] CFG_ADDR  = 8'h7F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd,
  input logic [7:0]        addr,
  input logic [7:0]        evt,
  input logic [7:0]        stat_q,
  input logic [7:0]        rdata,
  input logic [8*NFAN-1:0] duty_o,
  input logic [NFAN-1:0]   manual_o,
  input logic              lock_o,
  input logic              start_o,
  input logic              lpmd_o,
  input logic              ie_o
);

  wire in_shdn = lpmd_o && !start_o;

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> lock_o);

  assert_lpmd_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> $stable(lpmd_o));

  for (genvar g = 0; g < NFAN; g++) begin : g_duty
    assert_duty_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!manual_o[g] || lock_o) |=> $stable(duty_o[8*g +: 8]));
  end

  assert_evt_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 8'h00) |=> ((stat_q & $past(evt)) == $past(evt)));

  assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == STAT_ADDR && !in_shdn && evt == 8'h00) |=> (stat_q == 8'h00));

  assert_shdn_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_shdn && rd && addr != SPEC_ADDR && addr != CFG_ADDR) |-> (rdata == 8'h00));

  assert_ie_shdn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_shdn |=> $stable(ie_o));

endmodule

bind fanreg_access fanreg_access_chk #(
  .NFAN(NFAN), .STAT_ADDR(STAT_ADDR), .SPEC_ADDR(SPEC_ADDR), .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .addr(addr), .evt(evt), .stat_q(stat_q),
  .rdata(rdata), .duty_o(duty_o), .manual_o(manual_o), .lock_o(lock_o),
  .start_o(start_o), .lpmd_o(lpmd_o), .ie_o(ie_o)
);

// File: tb/fanreg_access_tb.sv
module fanreg_access_tb;
  localparam int NFAN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, evt = 8'h00;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic [8*NFAN-1:0] duty_o;
  logic [NFAN-1:0] manual_o;
  logic ie_o, start_o, lock_o, ovrd_o, lpmd_o;

  fanreg_access #(.NFAN(NFAN)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .evt(evt), .rdata(rdata), .duty_o(duty_o), .manual_o(manual_o),
    .ie_o(ie_o), .start_o(start_o), .lock_o(lock_o), .ovrd_o(ovrd_o), .lpmd_o(lpmd_o)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] m_test, m_stat, m_cfg;
  logic m_ie;
  logic [3:0] m_rsv;
  logic [2:0] m_lo;
  logic [7:0] m_duty [NFAN];
  logic [7:0] m_mode [NFAN];

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic bit m_shdn();
    return m_cfg[3] && !m_cfg[0];
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a == 8'h7F) return m_cfg;
    if (a == 8'h7C) return m_shdn() ? {5'b0, m_lo} : {m_ie, m_rsv, m_lo};
    if (m_shdn()) return 8'h00;
    if (a == 8'h10) return m_test;
    if (a == 8'h41) return m_stat;
    for (int i = 0; i < NFAN; i++) begin
      if (a == 8'(8'h30 + i)) return m_duty[i];
      if (a == 8'(8'h5C + i)) return m_mode[i];
    end
    return 8'h00;
  endfunction

  function automatic string tag(input logic [7:0] a);
    if (a == 8'h7F) return "R5";
    if (a == 8'h7C) return "R6";
    if (m_shdn()) return "R9";
    if (a == 8'h10) return "R7";
    if (a == 8'h41) return "R8";
    if (a >= 8'h30 && a < 8'(8'h30 + NFAN)) return "R3";
    if (a >= 8'h5C && a < 8'(8'h5C + NFAN)) return "R4";
    return "R2";
  endfunction

  task automatic m_reset();
    m_test = 0; m_stat = 0; m_cfg = 0; m_ie = 0; m_rsv = 0; m_lo = 0;
    for (int i = 0; i < NFAN; i++) begin m_duty[i] = 0; m_mode[i] = 0; end
  endtask

  task automatic m_update(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d, input logic [7:0] e);
    bit shd = m_shdn();
    bit lk = m_cfg[1];
    if (r && a == 8'h41 && !shd && e == 8'h00) m_stat = 8'h00;
    else m_stat = m_stat | e;
    if (w) begin
      if (a == 8'h7F) begin
        m_cfg[0] = d[0]; m_cfg[2] = d[2];
        if (!lk) begin m_cfg[1] = d[1]; m_cfg[7:3] = d[7:3]; end
      end else if (a == 8'h7C) begin
        m_lo = d[2:0];
        if (!shd) m_ie = d[7];
        if (!shd && !lk) m_rsv = d[6:3];
      end else if (!shd) begin
        if (a == 8'h10) m_test = d;
        for (int i = 0; i < NFAN; i++) begin
          if (a == 8'(8'h30 + i) && m_mode[i][0] && !lk) m_duty[i] = d;
          if (a == 8'(8'h5C + i) && !lk) m_mode[i] = d;
        end
      end
    end
  endtask

  task automatic check_outs();
    for (int i = 0; i < NFAN; i++) begin
      chk(duty_o[8*i +: 8], m_duty[i], "R3");
      chk({7'b0, manual_o[i]}, {7'b0, m_mode[i][0]}, "R4");
    end
    chk({7'b0, lock_o}, {7'b0, m_cfg[1]}, "R4");
    chk({6'b0, ovrd_o, start_o}, {6'b0, m_cfg[2], m_cfg[0]}, "R5");
    chk({7'b0, lpmd_o}, {7'b0, m_cfg[3]}, "R9");
    chk({7'b0, ie_o}, {7'b0, m_ie}, "R6");
  endtask

  task automatic step(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d, input logic [7:0] e);
    @(negedge clk);
    check_outs();
    wr = w; rd = r; addr = a; wdata = d; evt = e;
    #1;
    if (r) chk(rdata, m_read(a), tag(a));
    else chk(rdata, 8'h00, "R2");
    @(posedge clk);
    m_update(w, r, a, d, e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr = 0; rd = 0; evt = 0;
    repeat (3) @(posedge clk);
    m_reset();
    @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [7:0] ev_of(input int a, input int k);
    return ((a * 13 + k) % 11 == 0) ? 8'(1 << (a % 8)) : 8'h00;
  endfunction

  task automatic read_all(input int k);
    for (int a = 0; a < 256; a++) step(0, 1, 8'(a), 8'h00, ev_of(a, k));
  endtask

  task automatic write_all(input logic [7:0] pat, input int k);
    for (int a = 0; a < 256; a++) step(1, 0, 8'(a), 8'(a) ^ pat, ev_of(a, k + 3));
  endtask

  initial begin
    logic [7:0] pats [6] = '{8'h5A, 8'hA5, 8'h3C, 8'hFF, 8'h96, 8'h69};
    do_reset();
    // R1: reset values at every address and output
    @(negedge clk);
    chk({duty_o[7:0], 7'b0, lock_o}, 16'h0, "R1");
    for (int a = 0; a < 256; a++) step(0, 1, 8'(a), 8'h00, 8'h00);

    for (int r = 0; r < 6; r++) begin
      do_reset();
      if (r % 2 == 1)
        for (int i = 0; i < NFAN; i++) step(1, 0, 8'(8'h5C + i), 8'h01, 8'h00);
      if (r == 4) step(1, 0, 8'h7F, 8'h08, 8'h00);
      if (r == 5) step(1, 0, 8'h7F, 8'h02, 8'h00);
      read_all(r);
      write_all(pats[r], r);
      read_all(r + 1);
      write_all(~pats[r], r + 2);
      read_all(r + 2);
    end

    // R8: event in the same cycle as a clearing read stays latched
    do_reset();
    step(0, 0, 8'h00, 8'h00, 8'h01);
    step(0, 1, 8'h41, 8'h00, 8'h02);
    step(0, 1, 8'h41, 8'h00, 8'h00);
    step(0, 1, 8'h41, 8'h00, 8'h00);
    chk(m_stat, 8'h00, "R8");

    // R10: reserved configuration bits store without driving outputs
    step(1, 0, 8'h7F, 8'hF0, 8'h00);
    step(0, 1, 8'h7F, 8'h00, 8'h00);
    @(negedge clk);
    chk({4'b0, lpmd_o, ovrd_o, lock_o, start_o}, 8'h00, "R10");

    // R4: lock cannot be cleared once set
    step(1, 0, 8'h7F, 8'h02, 8'h00);
    step(1, 0, 8'h7F, 8'h00, 8'h00);
    @(negedge clk);
    chk({7'b0, lock_o}, 8'h01, "R4");
    step(0, 0, 8'h00, 8'h00, 8'h00);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule